// File: doc/BRIEF.md
# Triggered Burst Sample Capture

This block collects a burst of conversion results from a single analog channel every time an external trigger rises. On the trigger it asks an attached converter for a result through a start/done handshake, stores the returned 12-bit value, and asks again. It does this until the burst length chosen on its length input has been reached. It then stops by itself and waits for the next trigger.

Results land in a small ring buffer that is usually shorter than the burst. Later results therefore overwrite earlier ones. With the default setup, a 12-conversion burst goes into an 8-entry ring. The first four results of the pulse are thrown away, and the eight that survive cover the later window that matters, so no extra selection logic is needed. Software or a neighbouring block reads the ring through a combinational read port. An index output tells it where the oldest surviving entry sits, and flags report burst completion and triggers that were lost.

Top module: `burst_capture`

## Requirements
- R1: When the trigger rises while the block is idle, a burst starts: busy goes high and the conversion start output is high in the cycle after the edge is sampled. A trigger that stays high does not start another burst; only a new low-to-high transition does.
- R2: Each burst issues exactly N one-cycle start pulses. A new start is issued only after the done for the previous one. N is the length input when it lies in 1..16; a length of 0, or any value above 16, gives N = 16.
- R3: Result k of a burst (counting from 0) is written at ring index k mod DEPTH. The write index returns to 0 at every accepted trigger, so for N <= DEPTH, address i holds result i.
- R4: After a burst, the ring holds the last min(N, DEPTH) results. Reading from the oldest index upward, with wrap, returns them in conversion order. The read data follows the read address in the same cycle.
- R5: The cycle after the last result's done, a one-cycle done pulse appears and the complete flag goes high. The complete flag stays high until the next accepted trigger clears it.
- R6: At completion, the oldest index becomes N mod DEPTH when N >= DEPTH, or 0 otherwise. It keeps that value until the next completion.
- R7: A trigger edge seen while a burst is running does not restart or extend the burst. It sets the overrun flag, which stays high until reset.
- R8: After synchronous reset the block is idle, with start, busy, done, complete and overrun low, oldest index 0 and every ring entry 0.
- R9: A done pulse from the converter while no conversion is outstanding writes nothing into the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | External trigger level; its rising edge starts a burst |
| burst_len_i | input | 5 | Requested conversions per burst, sampled at the trigger |
| conv_start_o | output | 1 | One-cycle request for a conversion |
| conv_done_i | input | 1 | Converter result valid |
| conv_data_i | input | 12 | Converter result |
| rd_addr_i | input | 3 | Ring read address |
| rd_data_o | output | 12 | Ring entry at rd_addr_i |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse when a burst completes |
| complete_o | output | 1 | Sticky burst-complete flag |
| overrun_o | output | 1 | Sticky flag for a trigger lost during a burst |
| oldest_o | output | 3 | Ring index of the oldest surviving result |

## Verification
The bench covers these cases:
- Bursts longer than, equal to and shorter than the ring. A wrong wrap or a write index that is not reset would leave results in the wrong slots or report the wrong oldest index.
- Lengths of 0, 1, 16 and 20. A design that does not clamp would issue the wrong number of starts, and a design with an off-by-one stop would issue one too many or one too few.
- Converter latencies from one cycle up to 72 cycles, to catch a design that re-issues a start before its result returns.
- Trigger pulses in the middle of a burst, a trigger held high past the end of a burst, and a stray converter done while idle. These catch a design that restarts, fails to flag the lost trigger, retriggers on a level, or writes an unrequested result.

// File: rtl/burst_cap_pkg.sv
package burst_cap_pkg;

    localparam int DEF_DATA_W  = 12;
    localparam int DEF_DEPTH   = 8;
    localparam int DEF_MAX_LEN = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic complete;
        logic overrun;
    } seq_flags_t;

    // Requested length of 0 or above the limit means "use the limit".
    function automatic int unsigned clamp_len(int unsigned req, int unsigned lim);
        return (req == 0 || req > lim) ? lim : req;
    endfunction

    // Increment with wrap at an arbitrary depth.
    function automatic int unsigned wrap_inc(int unsigned idx, int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/burst_edge_det.sv
module burst_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/burst_ring.sv
module burst_ring #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[g] <= '0;
            else if (wr_en_i && wr_idx_i == AW'(g))
                slot[g] <= wr_data_i;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_addr_i == AW'(i)) rd_data_o = slot[i];
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_cap_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int MAX_LEN = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int LW     = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise_i,
    input  logic [LW-1:0] len_i,
    input  logic          conv_done_i,
    output logic          conv_start_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_idx_o,
    output seq_flags_t    flags_o,
    output logic [AW-1:0] oldest_o
);
    seq_state_e    state_q;
    logic [LW-1:0] target_q;
    logic [LW-1:0] count_q;
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] wptr_nx;
    logic          done_q;
    logic          complete_q;
    logic          overrun_q;
    logic [AW-1:0] oldest_q;
    logic          last_store;

    assign wr_en_o      = (state_q == SEQ_WAIT) && conv_done_i;
    assign wr_idx_o     = wptr_q;
    assign wptr_nx      = AW'(wrap_inc(int'(wptr_q), DEPTH));
    assign last_store   = wr_en_o && (count_q + LW'(1) == target_q);
    assign conv_start_o = (state_q == SEQ_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            target_q   <= '0;
            count_q    <= '0;
            wptr_q     <= '0;
            done_q     <= 1'b0;
            complete_q <= 1'b0;
            overrun_q  <= 1'b0;
            oldest_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (rise_i) begin
                        state_q    <= SEQ_REQ;
                        target_q   <= LW'(clamp_len(int'(len_i), MAX_LEN));
                        count_q    <= '0;
                        wptr_q     <= '0;
                        complete_q <= 1'b0;
                    end
                end
                SEQ_REQ: begin
                    state_q <= SEQ_WAIT;
                    if (rise_i) overrun_q <= 1'b1;
                end
                SEQ_WAIT: begin
                    if (rise_i) overrun_q <= 1'b1;
                    if (wr_en_o) begin
                        wptr_q  <= wptr_nx;
                        count_q <= count_q + LW'(1);
                        if (last_store) begin
                            state_q    <= SEQ_IDLE;
                            done_q     <= 1'b1;
                            complete_q <= 1'b1;
                            oldest_q   <= (int'(target_q) >= DEPTH) ? wptr_nx : '0;
                        end else begin
                            state_q <= SEQ_REQ;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign flags_o.busy     = (state_q != SEQ_IDLE);
    assign flags_o.done     = done_q;
    assign flags_o.complete = complete_q;
    assign flags_o.overrun  = overrun_q;
    assign oldest_o         = oldest_q;
endmodule

// File: rtl/burst_capture.sv
module burst_capture
    import burst_cap_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int DEPTH   = DEF_DEPTH,
    parameter int MAX_LEN = DEF_MAX_LEN,
    localparam int AW     = $clog2(DEPTH),
    localparam int LW     = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [LW-1:0]     burst_len_i,
    output logic              conv_start_o,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              complete_o,
    output logic              overrun_o,
    output logic [AW-1:0]     oldest_o
);
    logic          trig_rise;
    logic          wr_en;
    logic [AW-1:0] wr_idx;
    seq_flags_t    flags;

    burst_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (trig_i),
        .rise_o (trig_rise)
    );

    burst_seq #(
        .DEPTH   (DEPTH),
        .MAX_LEN (MAX_LEN)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .rise_i       (trig_rise),
        .len_i        (burst_len_i),
        .conv_done_i  (conv_done_i),
        .conv_start_o (conv_start_o),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .flags_o      (flags),
        .oldest_o     (oldest_o)
    );

    burst_ring #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_ring (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (conv_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    assign busy_o     = flags.busy;
    assign done_o     = flags.done;
    assign complete_o = flags.complete;
    assign overrun_o  = flags.overrun;
endmodule

// File: rtl/burst_capture_chk.sv
module burst_capture_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          conv_start_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          complete_o,
    input logic          overrun_o,
    input logic [AW-1:0] oldest_o
);
    // R1: a burst always begins with a conversion request
    assert_burst_opens_with_start_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> conv_start_o);

    // R2: start is a single-cycle pulse
    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |=> !conv_start_o);

    // R5: done is a single-cycle pulse and coincides with complete
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_done_sets_complete_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> complete_o);
    // R5: complete only clears when a new burst is requested
    assert_complete_clears_on_trigger_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(complete_o) |-> conv_start_o);

    // R6: oldest index changes only on completion
    assert_oldest_holds_R6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(oldest_o));

    // R7: overrun is sticky
    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);
endmodule

bind burst_capture burst_capture_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .conv_start_o (conv_start_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .complete_o   (complete_o),
    .overrun_o    (overrun_o),
    .oldest_o     (oldest_o)
);

// File: tb/burst_capture_tb.sv
`timescale 1ns/1ps
module burst_capture_tb;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [4:0]  blen = 5'd12;
    logic        cdone = 1'b0;
    logic [11:0] cdata = '0;
    logic [2:0]  rd_addr = '0;
    logic        cstart, busy, done, complete, overrun;
    logic [11:0] rd_data;
    logic [2:0]  oldest;

    always #4 clk = ~clk;

    burst_capture u_dut (
        .clk(clk), .rst(rst), .trig_i(trig), .burst_len_i(blen),
        .conv_start_o(cstart), .conv_done_i(cdone), .conv_data_i(cdata),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy),
        .done_o(done), .complete_o(complete), .overrun_o(overrun),
        .oldest_o(oldest)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    int lat = 72;
    int adc_cnt = 0;
    int next_val = 17;
    int starts_seen = 0;
    bit stray = 1'b0;
    bit sweep = 1'b1;
    int burst_data[$];

    always @(negedge clk) begin
        cdone = 1'b0;
        if (adc_cnt > 0) begin
            adc_cnt--;
            if (adc_cnt == 0) begin
                cdone = 1'b1;
                cdata = 12'(next_val);
                burst_data.push_back(next_val);
                next_val = (next_val * 5 + 123) % 4096;
            end
        end
        if (cstart === 1'b1) begin
            starts_seen++;
            adc_cnt = lat;
        end
        if (stray) begin
            cdone = 1'b1;
            cdata = 12'hABC;
            stray = 1'b0;
        end
        if (sweep) rd_addr <= rd_addr + 3'd1;
    end

    // ---------------- behavioural reference ----------------
    int  m_ph = 0, m_n = 0, m_k = 0, m_wp = 0, m_old = 0;
    bit  m_trig_prev = 0, m_done = 0, m_comp = 0, m_ovr = 0, m_live = 0;
    int  m_mem[D];

    function automatic int eff_len(int req);
        return (req == 0 || req > 16) ? 16 : req;
    endfunction

    always @(posedge clk) begin
        bit edge_seen;
        if (rst) begin
            m_ph = 0; m_n = 0; m_k = 0; m_wp = 0; m_old = 0;
            m_trig_prev = 0; m_done = 0; m_comp = 0; m_ovr = 0;
            foreach (m_mem[i]) m_mem[i] = 0;
            m_live = 1;
        end else begin
            edge_seen = trig && !m_trig_prev;
            m_trig_prev = trig;
            m_done = 0;
            if (m_ph == 0) begin
                if (edge_seen) begin
                    m_ph = 1; m_n = eff_len(int'(blen)); m_k = 0; m_wp = 0; m_comp = 0;
                end
            end else if (m_ph == 1) begin
                if (edge_seen) m_ovr = 1;
                m_ph = 2;
            end else begin
                if (edge_seen) m_ovr = 1;
                if (cdone) begin
                    m_mem[m_wp] = int'(cdata);
                    m_wp = (m_wp + 1) % D;
                    m_k++;
                    if (m_k == m_n) begin
                        m_ph = 0; m_done = 1; m_comp = 1;
                        m_old = (m_n >= D) ? m_wp : 0;
                    end else m_ph = 1;
                end
            end
        end
    end

    always begin
        @(negedge clk);
        #1;
        if (m_live && !rst) begin
            chk("R2 start",    int'(cstart),   int'(m_ph == 1));
            chk("R1 busy",     int'(busy),     int'(m_ph != 0));
            chk("R5 done",     int'(done),     int'(m_done));
            chk("R5 complete", int'(complete), int'(m_comp));
            chk("R7 overrun",  int'(overrun),  int'(m_ovr));
            chk("R6 oldest",   int'(oldest),   m_old);
            chk("R4 rd_data",  int'(rd_data),  m_mem[rd_addr]);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_burst(int len, int latency, int mid_trigs, bit hold);
        int n = eff_len(len);
        int m = (n < D) ? n : D;
        int exp_old = (n >= D) ? n % D : 0;
        @(negedge clk);
        lat = latency;
        blen = 5'(len);
        burst_data.delete();
        starts_seen = 0;
        trig = 1'b1;
        @(negedge clk);
        if (!hold) trig = 1'b0;
        #1;
        chk("R1 busy after trigger", int'(busy), 1);
        chk("R1 start after trigger", int'(cstart), 1);
        for (int t = 0; t < mid_trigs; t++) begin
            repeat (3) @(negedge clk);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
        end
        while (busy) @(negedge clk);
        #1;
        chk("R2 start count", starts_seen, n);
        chk("R5 complete after burst", int'(complete), 1);
        chk("R6 oldest index", int'(oldest), exp_old);
        sweep = 1'b0;
        for (int i = 0; i < m; i++) begin
            @(negedge clk);
            rd_addr = 3'((exp_old + i) % D);
            #2;
            // R3: short bursts sit at index = conversion number
            if (n <= D) chk("R3 slot order", int'(rd_data), burst_data[i]);
            else        chk("R4 survivor order", int'(rd_data), burst_data[n - m + i]);
        end
        if (hold) begin
            repeat (6) @(negedge clk);
            #1;
            chk("R1 held trigger no restart", int'(busy), 0);
            trig = 1'b0;
        end
        sweep = 1'b1;
    endtask

    initial begin
        int snap[D];
        repeat (3) @(negedge clk);
        #1;
        chk("R8 reset start", int'(cstart), 0);
        chk("R8 reset busy", int'(busy), 0);
        chk("R8 reset flags", int'({done, complete, overrun}), 0);
        chk("R8 reset oldest", int'(oldest), 0);
        chk("R8 reset ring", int'(rd_data), 0);
        @(negedge clk);
        rst = 1'b0;

        run_burst(12, 72, 0, 0);
        chk("R7 no overrun yet", int'(overrun), 0);
        run_burst(5, 3, 0, 0);
        run_burst(8, 2, 0, 0);
        run_burst(16, 1, 0, 0);
        run_burst(0, 4, 0, 0);
        run_burst(20, 2, 0, 0);
        run_burst(1, 5, 0, 0);
        run_burst(12, 10, 2, 0);
        chk("R7 overrun after mid-burst trigger", int'(overrun), 1);
        run_burst(9, 3, 0, 1);
        chk("R7 overrun still sticky", int'(overrun), 1);

        // R9: stray done while idle must not write
        sweep = 1'b0;
        for (int i = 0; i < D; i++) begin
            @(negedge clk); rd_addr = 3'(i); #2; snap[i] = int'(rd_data);
        end
        @(negedge clk);
        stray = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < D; i++) begin
            @(negedge clk); rd_addr = 3'(i); #2;
            chk("R9 stray done ignored", int'(rd_data), snap[i]);
        end
        sweep = 1'b1;
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule